// File: doc/BRIEF.md
# SPI Transmit Command/Data Queue

This block sits between a host (or DMA engine) and the serial shifter of an SPI master. Each entry pairs a command word with a data word. Entries arrive through one valid/ready push port. They leave, oldest first, through a valid/ready load port each time the shifter starts a new frame. The queue holds `DEPTH` entries (default four). It reports its occupancy and the index of the entry that the next frame will send. A fill flag tells the producer that there is room, and configuration routes that flag either to an interrupt line or to a DMA request line.

Back-pressure rules are as follows. `push_ready` is high exactly when the queue is not full. A push happens only on a cycle where `push_valid` and `push_ready` are both high. A `push_valid` seen while `push_ready` is low is dropped, and the producer may retry later. On the load side, `ld_valid` is high whenever at least one entry is stored. The shifter takes the head entry on a cycle where `ld_valid` and `ld_ready` are both high. If the shifter raises `ld_ready` while the queue is empty, that is an underflow.

A bypass configuration bit turns the queue into a single holding register, which gives double-buffered operation. In bypass, the counter, the fill flag and the underflow flag all behave as for a one-entry queue. The bypass bit must be fixed before the first push and must not change afterwards.

Top module: `spi_txq`

## Requirements
- R1: After reset, `occupancy` is 0, `next_ptr` is 0, `ld_valid` is 0, `fill_flag` is 1 and `unf_flag` is 0.
- R2: Entries leave on the load port in the order they were accepted, with each command still paired with its own data.
- R3: When the queue is full, `push_ready` is 0. A push attempt in that state is dropped and leaves the occupancy and the stored entries unchanged.
- R4: `occupancy` rises by one on each accepted push and falls by one on each accepted load. A cycle with both an accepted push and an accepted load leaves it unchanged.
- R5: `next_ptr` is the slot index (0 to DEPTH-1) of the head entry. It advances by one, wrapping from DEPTH-1 to 0, on each accepted load.
- R6: A cycle with `flush` high sets `occupancy`, `next_ptr` and the write position to 0 on the next edge. Any push or load offered in that cycle is ignored.
- R7: `fill_flag` is 1 whenever the queue is not full. Once the queue is full, the flag drops when the push that filled it carried `push_from_dma`=1, or when `fill_w1c` is pulsed while full. Otherwise it stays 1.
- R8: With `cfg_req_dma`=0, `fill_irq` mirrors `fill_flag` and `fill_dma_req` is 0. With `cfg_req_dma`=1, `fill_dma_req` mirrors `fill_flag` and `fill_irq` is 0.
- R9: `unf_flag` sets on the edge after a cycle where `ld_ready` is 1 while `ld_valid` is 0. It stays set until `unf_w1c` is pulsed, and a new underflow in the clearing cycle wins over the clear.
- R10: With `cfg_bypass`=1, the queue holds at most one entry: `push_ready` drops after one push, `next_ptr` stays 0, and the fill and underflow rules apply at depth one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_bypass | input | 1 | 1 = single holding register mode |
| cfg_req_dma | input | 1 | Fill flag routing: 0 = interrupt, 1 = DMA request |
| push_valid | input | 1 | Producer offers an entry |
| push_ready | output | 1 | Queue not full |
| push_cmd | input | CMD_W (16) | Command word of offered entry |
| push_data | input | DAT_W (16) | Data word of offered entry |
| push_from_dma | input | 1 | Offered push is a DMA write completion |
| flush | input | 1 | Empty the queue |
| ld_valid | output | 1 | Head entry available to the shifter |
| ld_ready | input | 1 | Shifter requests/accepts a frame |
| ld_cmd | output | CMD_W (16) | Head command word |
| ld_data | output | DAT_W (16) | Head data word |
| fill_w1c | input | 1 | Write-1 pulse clearing the fill flag |
| unf_w1c | input | 1 | Write-1 pulse clearing the underflow flag |
| occupancy | output | 3 | Number of stored entries |
| next_ptr | output | 2 | Slot index of the head entry |
| fill_flag | output | 1 | Room available / fill status |
| unf_flag | output | 1 | Sticky underflow status |
| fill_irq | output | 1 | Fill flag routed as interrupt |
| fill_dma_req | output | 1 | Fill flag routed as DMA request |

## Verification
On every cycle, the embedded assertions check several invariants. The occupancy never exceeds its capacity, and in bypass it never exceeds one. A blocked push cannot change the count, and a combined push and load holds it. A flush empties the queue, the fill flag stays high while the queue is not full, the two request lines are never both active, and the underflow flag sets and stays sticky as specified. Other behaviours only show in the bench's scenarios, where a scoreboard follows the data content and order through the load port. These are the pointer wrap sequence, the fill-flag clearing rule that separates DMA pushes from host pushes, the write-1-to-clear pulses, push-after-flush ordering, and the one-entry behaviour after a reset into bypass.

// File: rtl/spi_txq_pkg.sv
package spi_txq_pkg;
  localparam int CMD_W = 16;
  localparam int DAT_W = 16;

  typedef struct packed {
    logic [CMD_W-1:0] cmd;
    logic [DAT_W-1:0] data;
  } txq_entry_t;
endpackage

// File: rtl/spi_txq_store.sv
module spi_txq_store
  import spi_txq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int PTR_W = 2
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_idx,
  input  txq_entry_t       wr_entry,
  input  logic [PTR_W-1:0] rd_idx,
  output txq_entry_t       rd_entry
);
  txq_entry_t slot_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr_en && (wr_idx == PTR_W'(i))) slot_q[i] <= wr_entry;
    end
  end

  assign rd_entry = slot_q[rd_idx];
endmodule

// File: rtl/spi_txq_ctrl.sv
module spi_txq_ctrl #(
  parameter int DEPTH = 4,
  parameter int PTR_W = 2,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bypass,
  input  logic             push_req,
  input  logic             pop_req,
  input  logic             flush,
  output logic             push_fire,
  output logic             pop_fire,
  output logic             full,
  output logic             empty,
  output logic             full_nxt,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] cap;
  logic [CNT_W-1:0] cnt_nxt;

  function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign cap       = bypass ? CNT_W'(1) : CNT_W'(DEPTH);
  assign full      = (count == cap);
  assign empty     = (count == '0);
  assign push_fire = push_req && !full && !flush;
  assign pop_fire  = pop_req && !empty && !flush;

  always_comb begin
    cnt_nxt = count;
    if (flush) cnt_nxt = '0;
    else if (push_fire && !pop_fire) cnt_nxt = count + 1'b1;
    else if (pop_fire && !push_fire) cnt_nxt = count - 1'b1;
  end

  assign full_nxt = (cnt_nxt == cap);

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      count <= cnt_nxt;
      if (push_fire && !bypass) wr_ptr <= step_ptr(wr_ptr);
      if (pop_fire && !bypass)  rd_ptr <= step_ptr(rd_ptr);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH)); // R3
  AST_BLOCKED_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && full && !pop_req && !flush) |=> $stable(count)); // R3
  AST_PUSH_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (push_fire && pop_fire) |=> $stable(count)); // R4
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0 && rd_ptr == '0 && wr_ptr == '0)); // R6
endmodule

// File: rtl/spi_txq_flags.sv
module spi_txq_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic full,
  input  logic full_nxt,
  input  logic dma_done,
  input  logic fill_w1c,
  input  logic req_dma,
  input  logic shifter_req,
  input  logic empty,
  input  logic unf_w1c,
  output logic fill_q,
  output logic unf_q,
  output logic irq,
  output logic dma_req
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_q <= 1'b1;
      unf_q  <= 1'b0;
    end else begin
      if (!full_nxt)                 fill_q <= 1'b1;
      else if (dma_done || fill_w1c) fill_q <= 1'b0;

      if (shifter_req && empty) unf_q <= 1'b1;
      else if (unf_w1c)         unf_q <= 1'b0;
    end
  end

  assign irq     = fill_q && !req_dma;
  assign dma_req = fill_q && req_dma;

  AST_FILL_WHEN_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    !full |-> fill_q); // R7
  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq, dma_req})); // R8
  AST_UNF_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (shifter_req && empty) |=> unf_q); // R9
  AST_UNF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (unf_q && !unf_w1c) |=> unf_q); // R9
endmodule

// File: rtl/spi_txq.sv
module spi_txq
  import spi_txq_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_bypass,
  input  logic             cfg_req_dma,
  input  logic             push_valid,
  output logic             push_ready,
  input  logic [CMD_W-1:0] push_cmd,
  input  logic [DAT_W-1:0] push_data,
  input  logic             push_from_dma,
  input  logic             flush,
  output logic             ld_valid,
  input  logic             ld_ready,
  output logic [CMD_W-1:0] ld_cmd,
  output logic [DAT_W-1:0] ld_data,
  input  logic             fill_w1c,
  input  logic             unf_w1c,
  output logic [CNT_W-1:0] occupancy,
  output logic [PTR_W-1:0] next_ptr,
  output logic             fill_flag,
  output logic             unf_flag,
  output logic             fill_irq,
  output logic             fill_dma_req
);
  logic             push_fire, pop_fire, full, empty, full_nxt;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  txq_entry_t       wr_entry, rd_entry;

  assign wr_entry = '{cmd: push_cmd, data: push_data};

  spi_txq_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .bypass   (cfg_bypass),
    .push_req (push_valid),
    .pop_req  (ld_ready),
    .flush    (flush),
    .push_fire(push_fire),
    .pop_fire (pop_fire),
    .full     (full),
    .empty    (empty),
    .full_nxt (full_nxt),
    .wr_ptr   (wr_ptr),
    .rd_ptr   (rd_ptr),
    .count    (occupancy)
  );

  spi_txq_store #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_store (
    .clk     (clk),
    .wr_en   (push_fire),
    .wr_idx  (wr_ptr),
    .wr_entry(wr_entry),
    .rd_idx  (rd_ptr),
    .rd_entry(rd_entry)
  );

  spi_txq_flags u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .full       (full),
    .full_nxt   (full_nxt),
    .dma_done   (push_fire && push_from_dma),
    .fill_w1c   (fill_w1c),
    .req_dma    (cfg_req_dma),
    .shifter_req(ld_ready),
    .empty      (empty),
    .unf_w1c    (unf_w1c),
    .fill_q     (fill_flag),
    .unf_q      (unf_flag),
    .irq        (fill_irq),
    .dma_req    (fill_dma_req)
  );

  assign push_ready = !full;
  assign ld_valid   = !empty;
  assign ld_cmd     = rd_entry.cmd;
  assign ld_data    = rd_entry.data;
  assign next_ptr   = rd_ptr;

  AST_BYPASS_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_bypass |-> (occupancy <= CNT_W'(1))); // R10
  AST_BYPASS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_bypass |-> (next_ptr == '0)); // R10
  AST_LOAD_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    pop_fire |-> ld_valid); // R2
endmodule

// File: tb/spi_txq_bench.sv
`timescale 1ns/100ps
module spi_txq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_bypass = 1'b0, cfg_req_dma = 1'b0;
  logic        push_valid = 1'b0, push_from_dma = 1'b0, flush = 1'b0;
  logic [15:0] push_cmd = '0, push_data = '0;
  logic        ld_ready = 1'b0, fill_w1c = 1'b0, unf_w1c = 1'b0;
  logic        push_ready, ld_valid, fill_flag, unf_flag, fill_irq, fill_dma_req;
  logic [15:0] ld_cmd, ld_data;
  logic [2:0]  occupancy;
  logic [1:0]  next_ptr;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] exp_q [$];

  always #2.5 clk = ~clk;

  spi_txq u_spi_txq (
    .clk(clk), .rst_n(rst_n), .cfg_bypass(cfg_bypass), .cfg_req_dma(cfg_req_dma),
    .push_valid(push_valid), .push_ready(push_ready), .push_cmd(push_cmd),
    .push_data(push_data), .push_from_dma(push_from_dma), .flush(flush),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_cmd(ld_cmd), .ld_data(ld_data),
    .fill_w1c(fill_w1c), .unf_w1c(unf_w1c), .occupancy(occupancy),
    .next_ptr(next_ptr), .fill_flag(fill_flag), .unf_flag(unf_flag),
    .fill_irq(fill_irq), .fill_dma_req(fill_dma_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  // Driver: offers one entry for one cycle; records it if accepted.
  task automatic push(input logic [15:0] c, input logic [15:0] d, input logic dma);
    push_valid = 1'b1; push_cmd = c; push_data = d; push_from_dma = dma;
    if (push_ready && !flush) exp_q.push_back({c, d});
    step();
    push_valid = 1'b0; push_from_dma = 1'b0;
  endtask

  task automatic pop1();
    ld_ready = 1'b1; step(); ld_ready = 1'b0;
  endtask

  task automatic do_reset(input logic byp);
    rst_n = 1'b0; cfg_bypass = byp; exp_q.delete();
    step(); step();
    rst_n = 1'b1;
  endtask

  // Monitor: compares every accepted load against the scoreboard (R2).
  always @(negedge clk) begin
    if (rst_n && ld_valid && ld_ready && !flush) begin
      if (exp_q.size() == 0) chk("R2 load with empty scoreboard", 32'd1, 32'd0);
      else chk("R2 load order/content", {ld_cmd, ld_data}, exp_q.pop_front());
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset(1'b0);
    // R1 reset state
    chk("R1 occupancy", occupancy, 0);
    chk("R1 next_ptr", next_ptr, 0);
    chk("R1 ld_valid", ld_valid, 0);
    chk("R1 fill_flag", fill_flag, 1);
    chk("R1 unf_flag", unf_flag, 0);
    chk("R8 irq route", {fill_irq, fill_dma_req}, 2'b10);

    // Fill with host pushes (R4, R7)
    for (int i = 0; i < 4; i++) begin
      push(16'hC000 + 16'(i), 16'hD000 + 16'(i), 1'b0);
      chk("R4 count on push", occupancy, i + 1);
    end
    chk("R3 push_ready when full", push_ready, 0);
    chk("R7 host fill keeps flag", fill_flag, 1);
    push(16'hBAD0, 16'hBAD1, 1'b0);
    chk("R3 dropped push count", occupancy, 4);
    fill_w1c = 1'b1; step(); fill_w1c = 1'b0;
    chk("R7 w1c clears while full", fill_flag, 0);

    // Drain: order via monitor, pointer wrap (R5)
    for (int i = 0; i < 4; i++) begin
      pop1();
      chk("R5 next_ptr step", next_ptr, (i + 1) % 4);
      chk("R4 count on pop", occupancy, 3 - i);
      if (i == 0) chk("R7 flag back when room", fill_flag, 1);
    end

    // Simultaneous push and load (R4)
    push(16'h1111, 16'h2222, 1'b0);
    push(16'h3333, 16'h4444, 1'b0);
    push_valid = 1'b1; push_cmd = 16'h5555; push_data = 16'h6666; ld_ready = 1'b1;
    exp_q.push_back({16'h5555, 16'h6666});
    step();
    push_valid = 1'b0; ld_ready = 1'b0;
    chk("R4 push+pop holds count", occupancy, 2);
    pop1(); pop1();
    chk("R4 drained", occupancy, 0);

    // DMA routing and DMA completion clear (R8, R7)
    cfg_req_dma = 1'b1; #1;
    chk("R8 dma route", {fill_irq, fill_dma_req}, 2'b01);
    for (int i = 0; i < 3; i++) push(16'hA000 + 16'(i), 16'hE000 + 16'(i), 1'b1);
    chk("R7 dma push with room keeps flag", fill_flag, 1);
    push(16'hA003, 16'hE003, 1'b1);
    chk("R7 dma filling push clears flag", fill_flag, 0);
    chk("R8 dma req follows flag", fill_dma_req, 0);

    // Flush with a push offered (R6)
    flush = 1'b1; push_valid = 1'b1; push_cmd = 16'hF00D;
    step();
    flush = 1'b0; push_valid = 1'b0; exp_q.delete();
    chk("R6 flush count", occupancy, 0);
    chk("R6 flush ptr", next_ptr, 0);
    chk("R6 flush ld_valid", ld_valid, 0);
    chk("R7 flag after flush", fill_flag, 1);
    push(16'h7777, 16'h8888, 1'b0);
    pop1();
    chk("R6 push after flush order", next_ptr, 1);

    // Underflow (R9)
    ld_ready = 1'b1; step(); ld_ready = 1'b0;
    chk("R9 underflow sets", unf_flag, 1);
    step();
    chk("R9 underflow sticky", unf_flag, 1);
    ld_ready = 1'b1; unf_w1c = 1'b1; step(); ld_ready = 1'b0; unf_w1c = 1'b0;
    chk("R9 set wins over clear", unf_flag, 1);
    unf_w1c = 1'b1; step(); unf_w1c = 1'b0;
    chk("R9 w1c clears", unf_flag, 0);

    // Bypass: one-entry behaviour (R10)
    cfg_req_dma = 1'b0;
    do_reset(1'b1);
    push(16'h0ABC, 16'h0DEF, 1'b0);
    chk("R10 one entry count", occupancy, 1);
    chk("R10 push_ready low", push_ready, 0);
    chk("R10 host push keeps flag", fill_flag, 1);
    push(16'hBAD2, 16'hBAD3, 1'b0);
    chk("R10 extra push dropped", occupancy, 1);
    pop1();
    chk("R10 next_ptr stays 0", next_ptr, 0);
    chk("R10 empty after load", ld_valid, 0);
    push(16'h0123, 16'h0456, 1'b1);
    chk("R10 dma push clears flag", fill_flag, 0);
    pop1();
    chk("R10 flag back after load", fill_flag, 1);
    ld_ready = 1'b1; step(); ld_ready = 1'b0;
    chk("R10 underflow at depth one", unf_flag, 1);
    chk("R2 scoreboard drained", exp_q.size(), 0);

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule